// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the two software-selected sleep states of a small microcontroller. Software writes a byte-wide mode register at a fixed special-function address. Bit 0 requests a light sleep, in which the core stops but the timers, serial unit and interrupt logic keep their clock. Bit 1 requests deep sleep, in which the oscillator itself stops. Bit 2 chooses whether the I/O pins float while in deep sleep. The block turns those bits into registered clock enables for the core and for the peripherals, an oscillator enable, and a pin-float control. It also reports the current mode.

An enabled interrupt wakes the core out of light sleep. Deep sleep can be left only through the external reset pin, which has to work while no clock runs. The pin asynchronously restarts the oscillator. It then has to stay high for a qualification window, counted on the restarted clock, before the internal reset is issued. A short glitch therefore brings the chip back into deep sleep instead of resetting it. The internal reset is removed in step with the clock.

Top module: `lpm_ctrl`

## Requirements
- R1: A write with `wr_en_i` high and `wr_addr_i` equal to `PCON_ADDR` (default 0x87) loads bit 0 (light sleep), bit 1 (deep sleep) and bit 2 (float select) at the next rising edge. A write to any other address changes no output.
- R2: A write with both bit 0 and bit 1 set enters deep sleep only, and `idle_o` stays 0.
- R3: In light sleep, `cpu_clk_en_o` is 0 while `per_clk_en_o` and `osc_en_o` stay 1. This holds from the edge that captures the write.
- R4: At the edge that captures a deep-sleep write, `pd_o` goes to 1 and `cpu_clk_en_o`, `per_clk_en_o` and `osc_en_o` all go to 0. No further clock edge then occurs until the reset pin rises.
- R5: `irq_i` high at a rising edge during light sleep clears `idle_o` and sets `cpu_clk_en_o` to 1 at that edge. A light-sleep write in the same cycle as `irq_i` leaves `idle_o` at 0. `irq_i` outside light sleep changes nothing.
- R6: `port_float_o` is 1 only while in deep sleep with bit 2 set, and 0 in every other mode.
- R7: A rising `rst_pin_i` sets `osc_en_o` to 1 immediately, with no clock edge needed.
- R8: If `rst_pin_i` stays high across at least `RST_QUAL` rising edges, `sys_rst_o` is asserted. If it stays high across no more than `RST_QUAL`-4 edges, `sys_rst_o` stays 0, and a device that was in deep sleep returns to it with the oscillator stopped.
- R9: While `sys_rst_o` is high, the next edge clears all mode bits and sets both clock enables to 1. `sys_rst_o` falls at the third rising edge after `rst_pin_i` falls.
- R10: A write to the mode register while `sys_rst_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw oscillator clock; it stops while `osc_en_o` is low |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| wr_en_i | input | 1 | Special-function register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| irq_i | input | 1 | An enabled interrupt is pending |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Timer, serial and interrupt clock enable |
| osc_en_o | output | 1 | Oscillator run enable |
| port_float_o | output | 1 | Float the I/O pins |
| idle_o | output | 1 | Light sleep active |
| pd_o | output | 1 | Deep sleep active |
| sys_rst_o | output | 1 | Qualified internal reset |

## Verification
The bench stops its clock whenever the oscillator enable is low. A design that fails to stop the oscillator in deep sleep, or that never restarts it from the pin, shows up as a wrong count of clock edges or as a hang. A reset pulse a few edges too short must leave deep sleep intact. A controller that counted from the raw pin, or that let the oscillator enable fall back too early, would either reset on the glitch or lock up. Further directed cases cover a simultaneous write of both sleep bits, an interrupt in the same cycle as a light-sleep write, writes that arrive during reset, and the exact edge at which reset is released. A seeded random run compares every cycle of light-sleep entry and wake against a model in the bench.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int IDLE_BIT  = 0;
    localparam int PD_BIT    = 1;
    localparam int FLOAT_BIT = 2;

    typedef struct packed {
        logic idle;
        logic pd;
        logic flt;
        logic cpu_en;
        logic per_en;
        logic float_en;
    } mode_t;
endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
    parameter int RST_QUAL = 16
) (
    input  logic clk_i,
    input  logic rst_pin_i,
    output logic sys_rst_o,
    output logic busy_o
);
    localparam int CW = $clog2(RST_QUAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst;
    } qual_t;

    logic  s1_q, s2_q;
    qual_t st_d, st_q;

    // synchroniser: set at once by the pin, cleared through two edges
    always_ff @(posedge clk_i or posedge rst_pin_i) begin
        if (rst_pin_i) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= 1'b0;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!s2_q)
            st_d.cnt = '0;
        else if (st_q.cnt != CW'(RST_QUAL))
            st_d.cnt = st_q.cnt + 1'b1;
        st_d.rst = (st_d.cnt == CW'(RST_QUAL));
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sys_rst_o = st_q.rst;
    assign busy_o    = s1_q | s2_q | st_q.rst;
endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
    import lpm_pkg::*;
#(
    parameter int             ADDR_W    = 8,
    parameter int             DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PCON_ADDR = 8'h87
) (
    input  logic              clk_i,
    input  logic              sys_rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              irq_i,
    output mode_t             mode_o,
    output logic              pd_next_o
);
    mode_t mode_d, mode_q;
    logic  hit;

    always_comb begin
        mode_d = mode_q;
        hit    = wr_en_i && (wr_addr_i == PCON_ADDR) && !sys_rst_i;
        if (hit) begin
            mode_d.pd   = wr_data_i[PD_BIT];
            mode_d.idle = wr_data_i[IDLE_BIT] && !wr_data_i[PD_BIT];
            mode_d.flt  = wr_data_i[FLOAT_BIT];
        end
        if (irq_i)
            mode_d.idle = 1'b0;
        if (sys_rst_i) begin
            mode_d.idle = 1'b0;
            mode_d.pd   = 1'b0;
            mode_d.flt  = 1'b0;
        end
        mode_d.cpu_en   = !(mode_d.idle || mode_d.pd);
        mode_d.per_en   = !mode_d.pd;
        mode_d.float_en = mode_d.pd && mode_d.flt;
    end

    always_ff @(posedge clk_i) begin
        mode_q <= mode_d;
    end

    assign mode_o    = mode_q;
    assign pd_next_o = mode_d.pd;
endmodule

// File: rtl/lpm_osc_ctl.sv
module lpm_osc_ctl (
    input  logic clk_i,
    input  logic rst_pin_i,
    input  logic pd_next_i,
    input  logic rst_busy_i,
    output logic osc_en_o
);
    logic osc_d, osc_q;

    always_comb begin
        osc_d = !pd_next_i || rst_busy_i;
    end

    always_ff @(posedge clk_i or posedge rst_pin_i) begin
        if (rst_pin_i) osc_q <= 1'b1;
        else           osc_q <= osc_d;
    end

    assign osc_en_o = osc_q;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PCON_ADDR = 8'h87,
    parameter int                RST_QUAL  = 16
) (
    input  logic              clk_i,
    input  logic              rst_pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              irq_i,
    output logic              cpu_clk_en_o,
    output logic              per_clk_en_o,
    output logic              osc_en_o,
    output logic              port_float_o,
    output logic              idle_o,
    output logic              pd_o,
    output logic              sys_rst_o
);
    mode_t mode;
    logic  pd_next, rst_busy, sys_rst;

    lpm_rst_qual #(.RST_QUAL(RST_QUAL)) u_rst (
        .clk_i     (clk_i),
        .rst_pin_i (rst_pin_i),
        .sys_rst_o (sys_rst),
        .busy_o    (rst_busy)
    );

    lpm_mode_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PCON_ADDR (PCON_ADDR)
    ) u_mode (
        .clk_i     (clk_i),
        .sys_rst_i (sys_rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .irq_i     (irq_i),
        .mode_o    (mode),
        .pd_next_o (pd_next)
    );

    lpm_osc_ctl u_osc (
        .clk_i      (clk_i),
        .rst_pin_i  (rst_pin_i),
        .pd_next_i  (pd_next),
        .rst_busy_i (rst_busy),
        .osc_en_o   (osc_en_o)
    );

    logic unused_mode;
    assign unused_mode = mode.flt;

    assign cpu_clk_en_o = mode.cpu_en;
    assign per_clk_en_o = mode.per_en;
    assign port_float_o = mode.float_en;
    assign idle_o       = mode.idle;
    assign pd_o         = mode.pd;
    assign sys_rst_o    = sys_rst;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PCON_ADDR = 8'h87
) (
    input logic              clk_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              irq_i,
    input logic              cpu_clk_en_o,
    input logic              per_clk_en_o,
    input logic              port_float_o,
    input logic              idle_o,
    input logic              pd_o,
    input logic              sys_rst_o
);
    // properties are armed only once a first reset has been seen
    logic armed_q;
    always_ff @(posedge clk_i) begin
        if (sys_rst_o) armed_q <= 1'b1;
    end

    assert_both_bits_pd_R2: assert property (@(posedge clk_i) disable iff (!armed_q)
        (wr_en_i && wr_addr_i == PCON_ADDR && wr_data_i[1] && !sys_rst_o)
        |=> (pd_o && !idle_o));

    assert_idle_enables_R3: assert property (@(posedge clk_i) disable iff (!armed_q)
        idle_o |-> (!cpu_clk_en_o && per_clk_en_o));

    assert_pd_enables_R4: assert property (@(posedge clk_i) disable iff (!armed_q)
        pd_o |-> (!cpu_clk_en_o && !per_clk_en_o));

    assert_irq_wake_R5: assert property (@(posedge clk_i) disable iff (!armed_q)
        (idle_o && irq_i && !wr_en_i) |=> (!idle_o && cpu_clk_en_o));

    assert_float_only_pd_R6: assert property (@(posedge clk_i) disable iff (!armed_q)
        port_float_o |-> pd_o);

    assert_reset_clears_R9: assert property (@(posedge clk_i) disable iff (!armed_q)
        sys_rst_o |=> (!idle_o && !pd_o && cpu_clk_en_o && per_clk_en_o));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PCON_ADDR (PCON_ADDR)
) i_chk (
    .clk_i        (clk_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .irq_i        (irq_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .port_float_o (port_float_o),
    .idle_o       (idle_o),
    .pd_o         (pd_o),
    .sys_rst_o    (sys_rst_o)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
    localparam int         QUAL = 16;
    localparam logic [7:0] ADR  = 8'h87;

    logic       clk = 1'b0;
    logic       rst_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq = 1'b0;
    logic cpu_en, per_en, osc_en, flt, idle, pd, srst;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    bit done   = 1'b0;
    bit saw_rst = 1'b0;

    lpm_ctrl #(.PCON_ADDR(ADR), .RST_QUAL(QUAL)) i_lpm_ctrl (
        .clk_i(clk), .rst_pin_i(rst_pin), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .irq_i(irq), .cpu_clk_en_o(cpu_en),
        .per_clk_en_o(per_en), .osc_en_o(osc_en), .port_float_o(flt),
        .idle_o(idle), .pd_o(pd), .sys_rst_o(srst)
    );

    // 125 MHz; the clock halts low while the oscillator is disabled
    always begin
        #4;
        if (osc_en !== 1'b0 || clk) clk = ~clk;
    end
    always @(posedge clk) edges++;
    always @(posedge srst) saw_rst = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic a, input logic e);
        chk(a === e, req, int'(a), int'(e));
    endtask

    task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d, input logic i);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; irq = i;
        @(negedge clk);
        wr_en = 1'b0; irq = 1'b0;
    endtask

    task automatic hold_pin(input int n);
        rst_pin = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic model_idle(input logic cur, input logic we, input logic [7:0] a,
                                        input logic [7:0] d, input logic i);
        logic n;
        n = cur;
        if (we && a == ADR) n = d[0] && !d[1];
        if (i) n = 1'b0;
        return n;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic exp_idle;
        int   e0;
        int   seed;
        seed = $urandom(32'h5EED_1234);

        #20;
        rst_pin = 1'b1;
        #1;
        eq("R7 async osc start", osc_en, 1'b1);
        hold_pin(QUAL + 4);
        eq("R8 long pulse resets", srst, 1'b1);
        rst_pin = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        eq("R9 reset held 2 edges", srst, 1'b1);
        @(posedge clk); @(negedge clk);
        eq("R9 reset released 3rd edge", srst, 1'b0);
        eq("R9 idle clear", idle, 1'b0);
        eq("R9 pd clear", pd, 1'b0);
        eq("R9 cpu en", cpu_en, 1'b1);
        eq("R9 per en", per_en, 1'b1);
        eq("R9 osc en", osc_en, 1'b1);
        eq("R9 float off", flt, 1'b0);

        // R10: write during reset is dropped
        hold_pin(QUAL + 2);
        cyc(1'b1, ADR, 8'h01, 1'b0);
        rst_pin = 1'b0;
        cyc(1'b1, ADR, 8'h01, 1'b0);
        repeat (4) @(negedge clk);
        eq("R10 write in reset ignored", idle, 1'b0);
        eq("R10 cpu still on", cpu_en, 1'b1);

        // R1 wrong address, then correct
        cyc(1'b1, 8'h86, 8'h03, 1'b0);
        eq("R1 other addr idle", idle, 1'b0);
        eq("R1 other addr pd", pd, 1'b0);
        cyc(1'b1, ADR, 8'h05, 1'b0);
        eq("R1 idle set", idle, 1'b1);
        eq("R3 cpu gated", cpu_en, 1'b0);
        eq("R3 per running", per_en, 1'b1);
        eq("R3 osc running", osc_en, 1'b1);
        eq("R6 no float in idle", flt, 1'b0);

        // R5 wake and same-cycle collision, irq when awake
        cyc(1'b0, ADR, 8'h00, 1'b1);
        eq("R5 irq clears idle", idle, 1'b0);
        eq("R5 cpu back on", cpu_en, 1'b1);
        cyc(1'b1, ADR, 8'h01, 1'b1);
        eq("R5 collision idle", idle, 1'b0);
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        eq("R5 irq when awake", cpu_en, 1'b1);

        // random light-sleep traffic checked against the model
        exp_idle = idle;
        for (int k = 0; k < 300; k++) begin
            logic       we, i;
            logic [7:0] a, d;
            we = ($urandom % 2) == 0;
            a  = ($urandom % 2) == 0 ? ADR : 8'($urandom);
            d  = 8'($urandom) & 8'hFD;
            i  = ($urandom % 5) == 0;
            exp_idle = model_idle(exp_idle, we, a, d, i);
            cyc(we, a, d, i);
            eq("R5 random idle", idle, exp_idle);
            eq("R3 random cpu en", cpu_en, !exp_idle);
            eq("R3 random per en", per_en, 1'b1);
        end
        cyc(1'b0, 8'h00, 8'h00, 1'b1);

        // R2 / R4 deep sleep with both bits
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADR; wr_data = 8'h03;
        @(posedge clk); #1;
        wr_en = 1'b0;
        eq("R2 pd set", pd, 1'b1);
        eq("R2 idle not set", idle, 1'b0);
        eq("R4 cpu off", cpu_en, 1'b0);
        eq("R4 per off", per_en, 1'b0);
        eq("R4 osc off", osc_en, 1'b0);
        eq("R6 float bit clear", flt, 1'b0);
        #20;
        e0 = edges;
        #200;
        chk(edges == e0, "R4 clock halted", edges - e0, 0);

        // R8 short glitch: back to deep sleep
        saw_rst = 1'b0;
        hold_pin(QUAL - 4);
        rst_pin = 1'b0;
        #300;
        eq("R8 glitch no reset", saw_rst, 1'b0);
        eq("R8 glitch keeps pd", pd, 1'b1);
        eq("R8 glitch osc off", osc_en, 1'b0);

        // wake by full reset
        hold_pin(QUAL + 4);
        rst_pin = 1'b0;
        repeat (5) @(negedge clk);
        eq("R9 wake pd clear", pd, 1'b0);
        eq("R9 wake osc on", osc_en, 1'b1);
        eq("R9 wake cpu on", cpu_en, 1'b1);

        // R6 deep sleep with float select
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADR; wr_data = 8'h06;
        @(posedge clk); #1;
        wr_en = 1'b0;
        eq("R6 float in pd", flt, 1'b1);
        eq("R4 pd entered", pd, 1'b1);
        #100;
        hold_pin(QUAL + 4);
        rst_pin = 1'b0;
        repeat (5) @(negedge clk);
        eq("R6 float off after wake", flt, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule